// File: doc/BRIEF.md
# Shared-Counter Timer with PWM and Edge Capture

This block is a timer with one counter that serves two channels. The counter steps from a programmable start value up to a programmable modulo value and then reloads the start value. A selectable power-of-two prescaler sets how often it steps. The first channel uses the counter to drive an edge-aligned PWM output. The second channel records the counter value when a chosen edge arrives on an external input. The input passes through a two-flop synchronizer first.

Because both channels use the same counter, they share one timebase. The capture channel has an optional reset-on-capture mode. In that mode each captured edge reloads the start value, so the captured number gives the input period directly. The cost is that the PWM period is cut short each time this happens. When reset-on-capture is off, a period longer than one counter cycle is measured with the overflow count. This count holds the number of wraps since the previous capture and is latched together with each capture.

Software reaches the block through a plain parallel port: one write strobe and a combinational read mux. The start, modulo and compare values are first written to shadow copies. The working copies take them at the next wrap, so a running PWM never shows a partial period.

Top module: `shared_timer`

## Requirements
- R1: Register addresses (3 bits):
  - 0: control.
  - 1: start shadow.
  - 2: modulo shadow.
  - 3: compare shadow.
  - 4: capture value.
  - 5: overflow count latched with the capture.
  - 6: status, with bit 0 = capture valid and bit 1 = overrun.
  - 7: live count.
  - A write takes effect at the clock edge where wr_en is high. rd_data shows the register at rd_addr in the same cycle.
- R2: Values after reset: control 0, start 0, modulo all ones, compare 0, count 0, status 0. pwm_out is low.
- R3: Control bits [1:0] pick the counter clock. Value 01 runs the counter from the system clock. Any other value stops it. While stopped, the count is held at the start shadow, the working values follow the shadows, and the overflow count is cleared.
- R4: On each tick the count goes up by one. A tick at the modulo value reloads the start value. One period is therefore modulo − start + 1 ticks.
- R5: Control bits [4:2] hold a prescale value p. While running, the counter gets exactly one tick every 2^p clocks.
- R6: pwm_out is high while the count is below the working compare value and low otherwise. A compare value above the modulo value keeps pwm_out high.
- R7: A written start, modulo or compare value does not change the count sequence or the PWM until the next wrap, or until a cycle in which the counter is stopped.
- R8: Control bits [7:6] select the capture edge: 01 rising, 10 falling, 11 both, 00 none. Count the cycle in which cap_in changes as the first cycle. A selected edge latches the count held in the third cycle.
- R9: An edge of the kind not selected captures nothing. The status stays unchanged.
- R10: With control bit 5 set, a capture reloads the count with the working start value in the next cycle, whatever the tick. With the prescaler at 1, two captures N clocks apart read start + N − 1. The PWM restarts its high phase.
- R11: Address 5 reads the number of wraps between the previous capture (or the last stopped cycle) and this capture.
- R12: A capture sets the valid flag. A capture that arrives while the flag is already set also sets overrun. A read of address 4 with rd_en high clears both flags, unless a capture arrives in the same cycle: then only valid is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe (side effect on address 4) |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Edge-aligned PWM output |

## Verification
If the counter or its working values go wrong, the effect reaches the ports within one period. The live count at address 7 leaves the expected sequence, and pwm_out changes level at the wrong cycle. A shadow value adopted too early shows up as a PWM edge before the wrap. A fault in the synchronizer or the edge decode shifts the captured value by whole counts, or leaves the status flags wrong on the next read. A reset-on-capture fault appears as a wrong count in the cycle right after the capture.

// File: rtl/shtmr_pkg.sv
// Shared types and register addresses for the shared-counter timer.
// Assumes the data width is at least 8 bits so the control word fits.
package shtmr_pkg;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_START = 3'd1;
    localparam logic [2:0] A_MOD   = 3'd2;
    localparam logic [2:0] A_CMP   = 3'd3;
    localparam logic [2:0] A_CAP   = 3'd4;
    localparam logic [2:0] A_COVF  = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;
    localparam logic [2:0] A_CNT   = 3'd7;

    localparam logic [1:0] SRC_SYS = 2'b01;

    typedef struct packed {
        logic [1:0] edge_sel;   // bit0 rising, bit1 falling
        logic       rst_on_cap;
        logic [2:0] ps;
        logic [1:0] src;
    } ctrl_t;

endpackage

// File: rtl/shtmr_prescaler.sv
// Power-of-two tick generator. Emits one tick every 2^ps clocks while run is
// high; the divider restarts from zero whenever run is low.
module shtmr_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pdiv;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << ps);
    assign tick = run && ((pdiv & mask) == mask);

    // Free-running divider, cleared while the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pdiv <= '0;
        else                pdiv <= pdiv + DIV_W'(1);
    end
endmodule

// File: rtl/shtmr_capture.sv
// Input synchronizer and edge selector. Assumes cap_in is asynchronous;
// evt is a one-cycle pulse two clocks after the input changes.
module shtmr_capture #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_in,
    input  logic [1:0] edge_sel,
    output logic       evt
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign lvl = sync_q[SYNC_N-1];
    assign evt = (lvl && !prev_q && edge_sel[0]) || (!lvl && prev_q && edge_sel[1]);

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], cap_in};
            prev_q <= lvl;
        end
    end
endmodule

// File: rtl/shtmr_counter.sv
// Shared counter with working copies of start, modulo and compare.
// The working copies load from the shadows at a wrap or while stopped.
// Assumes start <= modulo in any programmed configuration.
module shtmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         cap_rst,
    input  logic [W-1:0] sh_start,
    input  logic [W-1:0] sh_mod,
    input  logic [W-1:0] sh_cmp,
    output logic [W-1:0] cnt,
    output logic [W-1:0] act_start,
    output logic [W-1:0] act_mod,
    output logic [W-1:0] act_cmp,
    output logic         wrap
);
    assign wrap = run && tick && !cap_rst && (cnt == act_mod);

    // Count, reload on wrap or capture, and adopt shadows at period borders.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            act_start <= '0;
            act_mod   <= '1;
            act_cmp   <= '0;
        end else if (!run) begin
            cnt       <= sh_start;
            act_start <= sh_start;
            act_mod   <= sh_mod;
            act_cmp   <= sh_cmp;
        end else if (cap_rst) begin
            cnt <= act_start;
        end else if (wrap) begin
            cnt       <= sh_start;
            act_start <= sh_start;
            act_mod   <= sh_mod;
            act_cmp   <= sh_cmp;
        end else if (tick) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/shared_timer.sv
// Top of the shared-counter timer: register port, capture latch, overflow
// count, status flags and PWM compare. Reads are combinational; a read of the
// capture register clears the valid and overrun flags.
module shared_timer #(
    parameter int W    = 16,
    parameter int PS_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         cap_in,
    output logic         pwm_out
);
    import shtmr_pkg::*;

    ctrl_t        ctrl;
    logic [W-1:0] sh_start, sh_mod, sh_cmp;
    logic [W-1:0] cnt, act_start, act_mod, act_cmp;
    logic [W-1:0] cap_val, cap_ovf, ovf_cnt;
    logic         run, tick, cap_evt, cap_rst, wrap, rd_cap;
    logic         valid, overrun;

    assign run     = (ctrl.src == SRC_SYS);
    assign cap_rst = cap_evt && ctrl.rst_on_cap;
    assign rd_cap  = rd_en && (rd_addr == A_CAP);
    assign pwm_out = (cnt < act_cmp);

    shtmr_prescaler #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ctrl.ps), .tick(tick)
    );

    shtmr_capture #(.SYNC_N(2)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .edge_sel(ctrl.edge_sel), .evt(cap_evt)
    );

    shtmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cap_rst(cap_rst),
        .sh_start(sh_start), .sh_mod(sh_mod), .sh_cmp(sh_cmp),
        .cnt(cnt), .act_start(act_start), .act_mod(act_mod),
        .act_cmp(act_cmp), .wrap(wrap)
    );

    // Control and shadow register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            sh_start <= '0;
            sh_mod   <= '1;
            sh_cmp   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl     <= ctrl_t'(wr_data[7:0]);
                A_START: sh_start <= wr_data;
                A_MOD:   sh_mod   <= wr_data;
                A_CMP:   sh_cmp   <= wr_data;
                default: ;
            endcase
        end
    end

    // Wraps since the last capture; latched and restarted on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ovf_cnt <= '0;
        else if (cap_evt)   ovf_cnt <= wrap ? W'(1) : '0;
        else if (wrap)      ovf_cnt <= ovf_cnt + W'(1);
    end

    // Capture latch and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
            cap_ovf <= '0;
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (cap_evt) begin
                cap_val <= cnt;
                cap_ovf <= ovf_cnt;
            end
            valid   <= cap_evt || (valid && !rd_cap);
            overrun <= (cap_evt && valid && !rd_cap) || (overrun && !rd_cap);
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{(W-8){1'b0}}, ctrl};
            A_START: rd_data = sh_start;
            A_MOD:   rd_data = sh_mod;
            A_CMP:   rd_data = sh_cmp;
            A_CAP:   rd_data = cap_val;
            A_COVF:  rd_data = cap_ovf;
            A_STAT:  rd_data = {{(W-2){1'b0}}, overrun, valid};
            default: rd_data = cnt;
        endcase
    end
endmodule

// File: rtl/shtmr_checker.sv
// Property checker for shared_timer, attached by bind below.
module shtmr_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic         cap_evt,
    input logic         cap_rst,
    input logic         wrap,
    input logic         rd_cap,
    input logic [W-1:0] cnt,
    input logic [W-1:0] sh_start,
    input logic [W-1:0] act_start,
    input logic [W-1:0] act_mod,
    input logic [W-1:0] act_cmp,
    input logic         valid,
    input logic         overrun,
    input logic         pwm_out
);
    a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == $past(sh_start)));

    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start <= act_mod) |-> (cnt >= act_start && cnt <= act_mod));

    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cap_rst && cnt == act_mod) |=> (cnt == $past(sh_start)));

    a_r6_const_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp > act_mod && cnt <= act_mod) |-> pwm_out);

    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(act_cmp) && $stable(act_mod) && $stable(act_start)));

    a_r10_cap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cap_rst) |=> (cnt == $past(act_start)));

    a_r12_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> valid);

    a_r12_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && valid && !rd_cap) |=> overrun);

    a_r12_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !cap_evt) |=> (!valid && !overrun));
endmodule

bind shared_timer shtmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cap_evt(cap_evt),
    .cap_rst(cap_rst), .wrap(wrap), .rd_cap(rd_cap), .cnt(cnt),
    .sh_start(sh_start), .act_start(act_start), .act_mod(act_mod),
    .act_cmp(act_cmp), .valid(valid), .overrun(overrun), .pwm_out(pwm_out)
);

// File: tb/shared_timer_tb_top.sv
// Scoreboard bench: driver tasks push expected items, a monitor at the
// falling edge pops them and compares against the ports.
module shared_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_in = 1'b0;
    logic        pwm_out;

    always #10 clk = ~clk;

    shared_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .pwm_out(pwm_out)
    );

    typedef struct {
        int          kind;   // 0: rd_data, 1: pwm_out
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state derived from the requirements.
    int tcnt = 0, tstart = 0, tmod = 65535, tcmp = 0;
    int sh_s = 0, sh_m = 65535, sh_c = 0;
    int twr = 0, lastw = 0, tpd = 0, tps = 0, tsel = 0;
    bit trun = 1'b0, trst = 1'b0;

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            act = (it.kind == 1) ? {15'd0, pwm_out} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
            end
        end
    end

    task automatic adv(input bit crst);
        if (!trun) begin
            tcnt = sh_s; tstart = sh_s; tmod = sh_m; tcmp = sh_c;
            tpd = 0; lastw = twr;
        end else if (crst) begin
            tcnt = tstart; tpd = (tpd + 1) % 128;
        end else begin
            int m;
            m = (1 << tps) - 1;
            if ((tpd & m) == m) begin
                if (tcnt == tmod) begin
                    tcnt = sh_s; tstart = sh_s; tmod = sh_m; tcmp = sh_c;
                    twr++;
                end else begin
                    tcnt++;
                end
            end
            tpd = (tpd + 1) % 128;
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        adv(1'b0);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        step();
        wr_en = 1'b0;
        case (a)
            3'd0: begin
                trun = (d[1:0] == 2'b01); tps = d[4:2]; trst = d[5]; tsel = d[7:6];
            end
            3'd1: sh_s = d;
            3'd2: sh_m = d;
            3'd3: sh_c = d;
            default: ;
        endcase
    endtask

    task automatic chk_rd(input logic [2:0] a, input int e, input string req);
        item_t it;
        rd_addr = a;
        rd_en = (a == 3'd4);
        it.kind = 0; it.exp = 16'(e); it.req = req;
        q.push_back(it);
        step();
        rd_en = 1'b0;
    endtask

    task automatic push_pwm(input string req);
        item_t it;
        it.kind = 1; it.exp = (tcnt < tcmp) ? 16'd1 : 16'd0; it.req = req;
        q.push_back(it);
    endtask

    // Change cap_in; returns the expected capture value and overflow count.
    task automatic edge_in(input bit v, output int ecap, output int eovf);
        bit fire;
        fire = (v != cap_in) && ((v && tsel[0]) || (!v && tsel[1]));
        cap_in = v;
        step();
        step();
        ecap = tcnt;
        eovf = twr - lastw;
        if (fire) lastw = twr;
        @(posedge clk); #1;
        adv(fire && trst);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c1, o1, c2, o2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset values, R1 address map
        chk_rd(3'd0, 0, "R2 ctrl");
        chk_rd(3'd2, 16'hFFFF, "R2 modulo");
        chk_rd(3'd1, 0, "R2 start");
        chk_rd(3'd7, 0, "R2 count");
        push_pwm("R2 pwm");
        chk_rd(3'd6, 0, "R2 status");

        wr(3'd2, 9);
        wr(3'd3, 4);
        wr(3'd1, 0);
        chk_rd(3'd2, 9, "R1 modulo shadow readback");
        wr(3'd0, 8'h41);

        // R4 count sequence, R6 PWM
        for (int i = 0; i < 20; i++) begin
            push_pwm("R6 pwm duty");
            chk_rd(3'd7, tcnt, "R4 count sequence");
        end

        // R7 shadow compare takes effect only at wrap
        wr(3'd3, 7);
        for (int i = 0; i < 20; i++) begin
            push_pwm("R7 shadow compare");
            step();
        end

        // R6 compare above modulo gives constant high
        wr(3'd3, 15);
        for (int i = 0; i < 12; i++) begin
            push_pwm("R6 compare above modulo");
            step();
        end

        // R5 prescale by 4
        wr(3'd0, 8'h49);
        for (int i = 0; i < 24; i++) chk_rd(3'd7, tcnt, "R5 prescaled count");
        wr(3'd0, 8'h41);

        // R8 rising capture, R12 flags
        edge_in(1'b1, c1, o1);
        chk_rd(3'd6, 1, "R12 valid set");
        chk_rd(3'd4, c1, "R8 rising capture value");
        chk_rd(3'd6, 0, "R12 read clears valid");

        // R9 falling edge ignored with rising selected
        edge_in(1'b0, c2, o2);
        chk_rd(3'd6, 0, "R9 unselected edge");

        // R11 overflow count between captures
        repeat (13) step();
        edge_in(1'b1, c2, o2);
        chk_rd(3'd5, o2, "R11 overflow count");
        chk_rd(3'd4, c2, "R8 second capture");
        if (o2 < 1) begin
            n_chk++; n_fail++;
            $display("FAIL R11 wraps: actual %0d expected >=1", o2);
        end

        // R12 overrun with both edges selected
        wr(3'd0, 8'hC1);
        edge_in(1'b0, c1, o1);
        edge_in(1'b1, c2, o2);
        chk_rd(3'd6, 3, "R12 overrun set");
        chk_rd(3'd4, c2, "R8 both-edge capture");
        chk_rd(3'd6, 0, "R12 read clears overrun");

        // R8 falling only, R9 rising ignored
        wr(3'd0, 8'h81);
        edge_in(1'b0, c1, o1);
        edge_in(1'b1, c2, o2);
        chk_rd(3'd6, 1, "R9 rising ignored when falling selected");
        chk_rd(3'd4, c1, "R8 falling capture value");

        // R10 reset-on-capture
        wr(3'd0, 0);
        wr(3'd1, 3);
        wr(3'd2, 200);
        wr(3'd3, 20);
        wr(3'd0, 8'h61);
        edge_in(1'b0, c1, o1);
        edge_in(1'b1, c1, o1);
        push_pwm("R10 pwm restarts high");
        chk_rd(3'd7, 3, "R10 count reloaded");
        edge_in(1'b0, c2, o2);
        repeat (20) step();
        edge_in(1'b1, c2, o2);
        chk_rd(3'd4, 29, "R10 period capture");
        chk_rd(3'd5, 0, "R11 no wrap with reset-on-capture");

        // R3 other clock-source value stops and holds at start
        wr(3'd1, 5);
        wr(3'd0, 8'h62);
        step();
        chk_rd(3'd7, 5, "R3 stopped count");
        chk_rd(3'd7, 5, "R3 stopped count held");

        repeat (2) step();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule